// File: doc/BRIEF.md
# Nibble-Coded Integer Execute Core

This block decodes and executes one instruction per clock from a tiny integer instruction set. A base instruction is a 16-bit word made of four 4-bit nibbles. Some instructions also take a second 16-bit word, the immediate, which arrives on its own input in the same cycle. The core holds sixteen 32-bit general registers and four condition flags: negative, zero, overflow and carry. Register 13 serves as frame pointer, 14 as link register and 15 as stack pointer. These are software conventions only and the hardware treats every register the same.

An upstream fetch stage presents an instruction with a valid strobe. In that cycle the core decodes the two opcode nibbles, reads its operands and computes the result. At the next rising edge it writes the destination registers and the flags. A combinational debug port reads any register. An illegal-opcode output reports for one cycle each instruction the core does not recognise.

Top module: `ministep_core`

## Requirements
- R1: After reset, every register reads zero, all four flags are low and `illegalOp` is low.
- R2: Nibble fields are: op1 = bits 15:12, op2 = bits 11:8, destination index = bits 7:4, source index = bits 3:0. While `instrValid` is low, no register and no flag changes, and `illegalOp` reads low after the next edge.
- R3: op1=4, op2=0 writes dest+src (modulo 2^32) into dest, visible on the debug port after the next rising edge.
- R4: Register adds update the flags. Carry is the carry out of bit 31. Overflow is set when both operands share a sign and the sum's sign differs. Zero and negative come from the 32-bit sum.
- R5: op1=4, op2=1 gives exactly the register result and the four flags that op1=4, op2=0 gives.
- R6: op1=4, op2=2 writes src plus the sign-extended 16-bit immediate into dest and leaves all four flags unchanged.
- R7: op1=5, op2=2 writes register src into dest and register (src+1) into register (dest+1). Both reads use the values from before the instruction, and index arithmetic wraps modulo 16.
- R8: op1=5, op2=3 writes the 4-bit source index itself, zero-extended to 32 bits, into dest.
- R9: op1=5, op2=4 writes register (src+1 modulo 16) into dest.
- R10: Any other op1/op2 pair with `instrValid` high raises `illegalOp` for the cycle after the edge. It changes no register and no flag.
- R11: `dbgData` always equals the register selected by `dbgSel`.
- R12: When dest and src of a register add are the same register, the result is twice the value the register held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction present this cycle |
| instrWord | input | 16 | Base instruction word |
| immWord | input | 16 | Immediate word, used by add-immediate |
| dbgSel | input | 4 | Debug register select |
| dbgData | output | 32 | Contents of the selected register |
| flagNeg | output | 1 | Negative flag |
| flagZero | output | 1 | Zero flag |
| flagOvf | output | 1 | Overflow flag |
| flagCarry | output | 1 | Carry flag |
| illegalOp | output | 1 | Previous instruction was not recognised |

## Verification
The register-pair copy writes two registers at the same edge. When src+1 equals dest, one of its reads names a register that its own other write replaces. The copy must still use the old value. The bench provokes this by wrapping the copy across register 15, and through random indices. It judges the result against a reference model that takes both reads before either write. The other case arises when an add's destination and source are the same register: the read and the write of that register fall in one cycle. The bench drives this with a chain of self-doublings up to the sign bit, where the overflow flag and the negative flag must both set.

// File: rtl/ministep_pkg.sv
package ministep_pkg;
  localparam int DATA_W  = 32;
  localparam int NIB_W   = 4;
  localparam int INSN_W  = 4 * NIB_W;
  localparam int IMM_W   = 16;
  localparam int REG_CNT = 16;
  localparam int IDX_W   = $clog2(REG_CNT);

  // Major / minor opcode values (op1 / op2 nibbles)
  localparam logic [NIB_W-1:0] GRP_ARITH = 4'd4;
  localparam logic [NIB_W-1:0] GRP_MOVE  = 4'd5;
  localparam logic [NIB_W-1:0] SUB_ADD   = 4'd0;
  localparam logic [NIB_W-1:0] SUB_ADDP  = 4'd1;
  localparam logic [NIB_W-1:0] SUB_ADDI  = 4'd2;
  localparam logic [NIB_W-1:0] SUB_PAIR  = 4'd2;
  localparam logic [NIB_W-1:0] SUB_IDX   = 4'd3;
  localparam logic [NIB_W-1:0] SUB_NEXT  = 4'd4;

  typedef enum logic [1:0] {
    WB_SUM  = 2'd0,
    WB_COPY = 2'd1,
    WB_IDX  = 2'd2,
    WB_NEXT = 2'd3
  } wbSel_e;

  typedef struct packed {
    logic   wrMain;   // write port to dest
    logic   wrPair;   // write port to dest+1
    wbSel_e wbSel;    // dest write data source
    logic   useImm;   // adder uses src + immediate
    logic   flagWr;   // update four flags
    logic   illegal;  // unrecognised opcode
  } ctrl_t;
endpackage

// File: rtl/ms_control.sv
module ms_control
  import ministep_pkg::*;
#(
  parameter int OP_W = NIB_W
) (
  input  logic            instrValid,
  input  logic [OP_W-1:0] opMajor,
  input  logic [OP_W-1:0] opMinor,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '{wrMain: 1'b0, wrPair: 1'b0, wbSel: WB_SUM,
             useImm: 1'b0, flagWr: 1'b0, illegal: 1'b0};
    if (instrValid) begin
      unique case (opMajor)
        GRP_ARITH: begin
          unique case (opMinor)
            SUB_ADD, SUB_ADDP: begin
              ctrl.wrMain = 1'b1;
              ctrl.flagWr = 1'b1;
            end
            SUB_ADDI: begin
              ctrl.wrMain = 1'b1;
              ctrl.useImm = 1'b1;
            end
            default: ctrl.illegal = 1'b1;
          endcase
        end
        GRP_MOVE: begin
          unique case (opMinor)
            SUB_PAIR: begin
              ctrl.wrMain = 1'b1;
              ctrl.wrPair = 1'b1;
              ctrl.wbSel  = WB_COPY;
            end
            SUB_IDX: begin
              ctrl.wrMain = 1'b1;
              ctrl.wbSel  = WB_IDX;
            end
            SUB_NEXT: begin
              ctrl.wrMain = 1'b1;
              ctrl.wbSel  = WB_NEXT;
            end
            default: ctrl.illegal = 1'b1;
          endcase
        end
        default: ctrl.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ms_datapath.sv
module ms_datapath
  import ministep_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int RCNT = REG_CNT,
  parameter int IW   = IMM_W,
  localparam int XW  = $clog2(RCNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [XW-1:0] dstIdx,
  input  logic [XW-1:0] srcIdx,
  input  logic [IW-1:0] immWord,
  input  logic [XW-1:0] dbgSel,
  output logic [DW-1:0] dbgData,
  output logic [DW-1:0] wbData,
  output logic          flagNeg,
  output logic          flagZero,
  output logic          flagOvf,
  output logic          flagCarry,
  output logic          illegalOp
);
  logic [DW-1:0] regs    [RCNT];
  logic [DW-1:0] regNext [RCNT];

  logic [XW-1:0] srcNext;
  logic [XW-1:0] dstNext;
  logic [DW-1:0] dstVal, srcVal, srcNextVal;
  logic [DW-1:0] opA, opB, immExt, sum;
  logic [DW:0]   sumWide;
  logic          carryOut, ovfOut;

  assign srcNext    = srcIdx + 1'b1;   // wraps modulo RCNT
  assign dstNext    = dstIdx + 1'b1;
  assign dstVal     = regs[dstIdx];
  assign srcVal     = regs[srcIdx];
  assign srcNextVal = regs[srcNext];
  assign dbgData    = regs[dbgSel];

  // Adder: register form uses dest+src, immediate form src+imm
  assign immExt  = {{(DW-IW){immWord[IW-1]}}, immWord};
  assign opA     = ctrl.useImm ? srcVal : dstVal;
  assign opB     = ctrl.useImm ? immExt : srcVal;
  assign sumWide = {1'b0, opA} + {1'b0, opB};
  assign sum     = sumWide[DW-1:0];
  assign carryOut = sumWide[DW];
  assign ovfOut   = (opA[DW-1] == opB[DW-1]) && (sum[DW-1] != opA[DW-1]);

  always_comb begin
    unique case (ctrl.wbSel)
      WB_SUM:  wbData = sum;
      WB_COPY: wbData = srcVal;
      WB_IDX:  wbData = {{(DW-XW){1'b0}}, srcIdx};
      WB_NEXT: wbData = srcNextVal;
      default: wbData = sum;
    endcase
  end

  // Next-state per register: dest port wins, pair port hits dest+1
  for (genvar g = 0; g < RCNT; g++) begin : g_reg
    always_comb begin
      regNext[g] = regs[g];
      if (ctrl.wrPair && (dstNext == XW'(g)))
        regNext[g] = srcNextVal;
      if (ctrl.wrMain && (dstIdx == XW'(g)))
        regNext[g] = wbData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RCNT; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < RCNT; i++) regs[i] <= regNext[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagNeg   <= 1'b0;
      flagZero  <= 1'b0;
      flagOvf   <= 1'b0;
      flagCarry <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      illegalOp <= ctrl.illegal;
      if (ctrl.flagWr) begin
        flagNeg   <= sum[DW-1];
        flagZero  <= (sum == '0);
        flagOvf   <= ovfOut;
        flagCarry <= carryOut;
      end
    end
  end
endmodule

// File: rtl/ministep_core.sv
module ministep_core
  import ministep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instrValid,
  input  logic [INSN_W-1:0] instrWord,
  input  logic [IMM_W-1:0]  immWord,
  input  logic [IDX_W-1:0]  dbgSel,
  output logic [DATA_W-1:0] dbgData,
  output logic              flagNeg,
  output logic              flagZero,
  output logic              flagOvf,
  output logic              flagCarry,
  output logic              illegalOp
);
  ctrl_t             ctrlBus;
  logic [DATA_W-1:0] wbData;
  logic [NIB_W-1:0]  opMajor, opMinor;
  logic [IDX_W-1:0]  dstIdx, srcIdx;

  assign opMajor = instrWord[4*NIB_W-1 -: NIB_W];
  assign opMinor = instrWord[3*NIB_W-1 -: NIB_W];
  assign dstIdx  = instrWord[2*NIB_W-1 -: IDX_W];
  assign srcIdx  = instrWord[NIB_W-1   -: IDX_W];

  ms_control #(.OP_W(NIB_W)) u_ctl (
    .instrValid (instrValid),
    .opMajor    (opMajor),
    .opMinor    (opMinor),
    .ctrl       (ctrlBus)
  );

  ms_datapath #(.DW(DATA_W), .RCNT(REG_CNT), .IW(IMM_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrlBus),
    .dstIdx    (dstIdx),
    .srcIdx    (srcIdx),
    .immWord   (immWord),
    .dbgSel    (dbgSel),
    .dbgData   (dbgData),
    .wbData    (wbData),
    .flagNeg   (flagNeg),
    .flagZero  (flagZero),
    .flagOvf   (flagOvf),
    .flagCarry (flagCarry),
    .illegalOp (illegalOp)
  );
endmodule

// File: rtl/ms_checker.sv
module ms_checker
  import ministep_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              instrValid,
  input logic [INSN_W-1:0] instrWord,
  input ctrl_t             ctrl,
  input logic [DATA_W-1:0] wbData,
  input logic [3:0]        flags,
  input logic              illegalOp
);
  logic isAddi;
  assign isAddi = instrValid && instrWord[15:12] == GRP_ARITH && instrWord[11:8] == SUB_ADDI;

  AST_FLAGS_TRACK_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.flagWr |=> (flags[2] == ($past(wbData) == '0)) && (flags[3] == $past(wbData[DATA_W-1]))); // R4
  AST_ADDI_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    isAddi |=> $stable(flags)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !instrValid |=> ($stable(flags) && !illegalOp)); // R2
  AST_ILLEGAL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    illegalOp |-> $stable(flags)); // R10
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.wrMain, ctrl.illegal})); // R10
  AST_PAIR_WITH_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.wrPair |-> ctrl.wrMain); // R7
  AST_INDEX_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.wrMain && ctrl.wbSel == WB_IDX) |-> (wbData[DATA_W-1:IDX_W] == '0)); // R8
endmodule

bind ministep_core ms_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instrValid (instrValid),
  .instrWord  (instrWord),
  .ctrl       (ctrlBus),
  .wbData     (wbData),
  .flags      ({flagNeg, flagZero, flagOvf, flagCarry}),
  .illegalOp  (illegalOp)
);

// File: tb/sim_ministep_core.sv
`timescale 1ns/10ps
module sim_ministep_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instrValid;
  logic [15:0] instrWord;
  logic [15:0] immWord;
  logic [3:0]  dbgSel;
  logic [31:0] dbgData;
  logic        flagNeg, flagZero, flagOvf, flagCarry, illegalOp;

  int nChecks = 0;
  int nFail   = 0;

  logic [31:0] refRegs [16];
  logic refN, refZ, refV, refC, refIll;

  always #2 clk = ~clk;

  ministep_core u0 (
    .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .instrWord(instrWord),
    .immWord(immWord), .dbgSel(dbgSel), .dbgData(dbgData), .flagNeg(flagNeg),
    .flagZero(flagZero), .flagOvf(flagOvf), .flagCarry(flagCarry), .illegalOp(illegalOp)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic isLegal(input logic [3:0] a, input logic [3:0] b);
    return (a == 4'd4 && b <= 4'd2) || (a == 4'd5 && b >= 4'd2 && b <= 4'd4);
  endfunction

  // Reference model of one instruction (R3..R10, R12)
  task automatic refStep(input logic v, input logic [15:0] w, input logic [15:0] imm);
    logic [3:0] a, b, d, s;
    logic [31:0] x, y, t0, t1;
    logic [32:0] wide;
    a = w[15:12]; b = w[11:8]; d = w[7:4]; s = w[3:0];
    refIll = 1'b0;
    if (!v) return;
    if (!isLegal(a, b)) begin refIll = 1'b1; return; end
    if (a == 4'd4 && b != 4'd2) begin
      x = refRegs[d]; y = refRegs[s];
      wide = {1'b0, x} + {1'b0, y};
      refRegs[d] = wide[31:0];
      refC = wide[32];
      refV = (x[31] == y[31]) && (wide[31] != x[31]);
      refZ = (wide[31:0] == 32'd0);
      refN = wide[31];
    end else if (a == 4'd4) begin
      refRegs[d] = refRegs[s] + {{16{imm[15]}}, imm};
    end else if (b == 4'd2) begin
      t0 = refRegs[s]; t1 = refRegs[s + 4'd1];
      refRegs[d] = t0;
      refRegs[d + 4'd1] = t1;
    end else if (b == 4'd3) begin
      refRegs[d] = {28'd0, s};
    end else begin
      refRegs[d] = refRegs[s + 4'd1];
    end
  endtask

  // Compare all visible state; registers read through the debug port (R11)
  task automatic compareAll(input string req);
    chk(req, "flagNeg",   {31'd0, flagNeg},   {31'd0, refN});
    chk(req, "flagZero",  {31'd0, flagZero},  {31'd0, refZ});
    chk(req, "flagOvf",   {31'd0, flagOvf},   {31'd0, refV});
    chk(req, "flagCarry", {31'd0, flagCarry}, {31'd0, refC});
    chk(req, "illegalOp", {31'd0, illegalOp}, {31'd0, refIll});
    for (int i = 0; i < 16; i++) begin
      dbgSel = 4'(i);
      #0.05;
      chk(req, $sformatf("reg%0d", i), dbgData, refRegs[i]);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] w, input logic [15:0] imm, input string req);
    instrValid = v; instrWord = w; immWord = imm;
    refStep(v, w, imm);
    @(negedge clk);
    compareAll(req);
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) refRegs[i] = 32'd0;
    refN = 0; refZ = 0; refV = 0; refC = 0; refIll = 0;
    rst_n = 1'b0; instrValid = 1'b0; instrWord = '0; immWord = '0; dbgSel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compareAll("R1");

    // Directed corners
    step(1, 16'h4210, 16'hFFFF, "R6");   // r1 = r0 + -1
    step(1, 16'h4220, 16'h0001, "R6");   // r2 = r0 + 1
    step(1, 16'h4012, 16'h0000, "R4");   // r1 = 0xFFFFFFFF + 1 -> 0, C=1, Z=1
    for (int i = 0; i < 30; i++) step(1, 16'h4022, 16'h0, "R12"); // r2 doubles
    step(1, 16'h4122, 16'h0, "R4");      // 0x40000000*2 -> V=1, N=1 (second encoding, R5)
    step(1, 16'h42E0, 16'h8000, "R6");   // r14 = -32768, flags held
    step(1, 16'h52FE, 16'h0, "R7");      // r15=r14, r0=r15(old): wrap
    step(1, 16'h5339, 16'h0, "R8");      // r3 = 9
    step(1, 16'h544F, 16'h0, "R9");      // r4 = r0
    step(1, 16'h6000, 16'h0, "R10");     // illegal
    step(1, 16'h4F00, 16'h0, "R10");     // illegal minor in arith group
    step(0, 16'h4011, 16'h0, "R2");      // not valid: nothing changes
    step(1, 16'h5011, 16'h0, "R10");
    step(1, 16'h4033, 16'h0, "R3");

    // Constrained random mix
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] w;
      logic [15:0] imm;
      logic [3:0] a, b;
      int k;
      string req;
      k = $urandom_range(0, 11);
      imm = 16'($urandom);
      w[7:0] = 8'($urandom);
      case (k)
        0, 1:  begin w[15:8] = 8'h40; req = "R3"; end
        2, 3:  begin w[15:8] = 8'h41; req = "R5"; end
        4, 5:  begin w[15:8] = 8'h42; req = "R6"; end
        6:     begin w[15:8] = 8'h52; req = "R7"; end
        7:     begin w[15:8] = 8'h53; req = "R8"; end
        8:     begin w[15:8] = 8'h54; req = "R9"; end
        9:     begin w[15:8] = 8'h40; w[7:4] = w[3:0]; req = "R12"; end
        10:    begin
                 do begin a = 4'($urandom); b = 4'($urandom); end while (isLegal(a, b));
                 w[15:8] = {a, b}; req = "R10";
               end
        default: begin w[15:8] = 8'($urandom); req = "R2"; end
      endcase
      step(k != 11, w, imm, req);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule